// File: doc/BRIEF.md
# Redundant Majority Bundle Stage

This block performs one redundant three-input majority operation on three bundles of N parallel lines. Each bundle carries N copies of one logical signal, some of which may be wrong. A first layer of N majority gates combines the three bundles line by line. An optional second layer then corrects errors. It makes three copies of every first-layer output, shuffles the 3N copies with a permutation fixed at build time, cuts the shuffled list into N groups of three, and takes the majority of each group. The result is again a bundle of N lines. It is never reduced to a single bit, so stages can be chained and each stage keeps the redundancy.

Two fault masks, one per layer, invert chosen gate outputs. A bench uses them to model failed gates. One parameter removes the second layer, so the first layer drives the stage output. A second parameter adds a single output register. With restoration the stage uses 2N gates for one logical majority.

Top module: `maj_mux_stage`

## Requirements
- R1: First-layer gate i drives maj(bundle_a[i], bundle_b[i], bundle_c[i]) XOR exec_fault[i]. With RESTORE=0, this value appears on bundle_out[i].
- R2: With RESTORE=1, position k of the shuffled list (0 ≤ k < 3N) carries first-layer line ((k·PERM_STRIDE + PERM_OFFSET) mod 3N) mod N. Second-layer gate g takes the majority of positions 3g, 3g+1 and 3g+2.
- R3: With RESTORE=1, rest_fault[g] inverts second-layer output g and no other line.
- R4: With RESTORE=0, rest_fault has no effect on bundle_out.
- R5: With REGISTER_OUT=1, bundle_out shows the result for the inputs present at the previous rising clock edge. A clock edge with rst_n low clears bundle_out to all zeros.
- R6: When all three bundles are all ones, or all three are all zeros, and both masks are zero, every output line equals that value. This holds in both modes.
- R7: The default table (N=5, stride 7, offset 4) gives each second-layer gate three distinct first-layer lines. With restoration, a single first-layer fault under all-ones or all-zeros inputs therefore leaves bundle_out uncorrupted.
- R8: With RESTORE=1, a single wrong line in one input bundle under otherwise consensus inputs is corrected at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| bundle_a | input | N | First input bundle |
| bundle_b | input | N | Second input bundle |
| bundle_c | input | N | Third input bundle |
| exec_fault | input | N | Inversion mask for the first-layer gates |
| rest_fault | input | N | Inversion mask for the second-layer gates |
| bundle_out | output | N | Result bundle |

## Verification
A wrong entry in the shuffle shows as an output line that disagrees with the bench's majority model on mixed input patterns. It is visible one clock after the pattern is applied when the output is registered, and at once otherwise. A mask bit routed to the wrong gate flips a line other than the one the bench expects, on the same cycle as the result. A broken output register shows as a result that arrives one cycle early or late, or as a nonzero value after reset.

// File: rtl/maj_mux_pkg.sv
package maj_mux_pkg;

    // Three-input majority vote
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // First-layer line feeding shuffled position k of the 3n-entry list
    function automatic int perm_line(input int k, input int n,
                                     input int stride, input int offset);
        return ((k * stride + offset) % (3 * n)) % n;
    endfunction

endpackage

// File: rtl/maj_exec_layer.sv
module maj_exec_layer #(
    parameter int N = 5
) (
    input  logic [N-1:0] in_a,
    input  logic [N-1:0] in_b,
    input  logic [N-1:0] in_c,
    input  logic [N-1:0] fault,
    output logic [N-1:0] lines
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign lines[i] = maj_mux_pkg::maj3(in_a[i], in_b[i], in_c[i]) ^ fault[i];
    end
endmodule

// File: rtl/maj_restore_layer.sv
module maj_restore_layer #(
    parameter int N           = 5,
    parameter int PERM_STRIDE = 7,
    parameter int PERM_OFFSET = 4
) (
    input  logic [N-1:0] exec_lines,
    input  logic [N-1:0] fault,
    output logic [N-1:0] lines
);
    localparam int SPAN = 3 * N;

    // Triplicated list: entry j is a copy of first-layer line j mod N
    logic [SPAN-1:0] tripled;
    logic [SPAN-1:0] shuffled;

    for (genvar j = 0; j < SPAN; j++) begin : g_copy
        assign tripled[j] = exec_lines[j % N];
    end

    for (genvar k = 0; k < SPAN; k++) begin : g_shuffle
        localparam int SRC = (k * PERM_STRIDE + PERM_OFFSET) % SPAN;
        assign shuffled[k] = tripled[SRC];
    end

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign lines[g] = maj_mux_pkg::maj3(shuffled[3*g], shuffled[3*g+1],
                                            shuffled[3*g+2]) ^ fault[g];
    end
endmodule

// File: rtl/maj_out_reg.sv
module maj_out_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stage_in,
    output logic [N-1:0] stage_out
);
    typedef struct packed {
        logic [N-1:0] line;
    } out_state_t;

    out_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.line = stage_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign stage_out = state_q.line;

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_out == $past(stage_in));
endmodule

// File: rtl/maj_mux_stage.sv
module maj_mux_stage #(
    parameter int N            = 5,
    parameter bit RESTORE      = 1'b1,
    parameter bit REGISTER_OUT = 1'b1,
    parameter int PERM_STRIDE  = 7,
    parameter int PERM_OFFSET  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] bundle_a,
    input  logic [N-1:0] bundle_b,
    input  logic [N-1:0] bundle_c,
    input  logic [N-1:0] exec_fault,
    input  logic [N-1:0] rest_fault,
    output logic [N-1:0] bundle_out
);
    localparam logic [N-1:0] ALL_ONE = '1;

    logic [N-1:0] exec_lines;
    logic [N-1:0] stage_comb;

    maj_exec_layer #(.N(N)) u_exec (
        .in_a  (bundle_a),
        .in_b  (bundle_b),
        .in_c  (bundle_c),
        .fault (exec_fault),
        .lines (exec_lines)
    );

    if (RESTORE) begin : g_restore
        maj_restore_layer #(
            .N           (N),
            .PERM_STRIDE (PERM_STRIDE),
            .PERM_OFFSET (PERM_OFFSET)
        ) u_rest (
            .exec_lines (exec_lines),
            .fault      (rest_fault),
            .lines      (stage_comb)
        );

        // R3
        rest_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $stable({bundle_a, bundle_b, bundle_c, exec_fault}) |->
            (stage_comb ^ $past(stage_comb)) == (rest_fault ^ $past(rest_fault)));
    end else begin : g_bypass
        assign stage_comb = exec_lines;

        // R4
        bypass_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $stable({bundle_a, bundle_b, bundle_c, exec_fault}) |-> $stable(stage_comb));

        // R1
        exec_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $stable({bundle_a, bundle_b, bundle_c}) |->
            (stage_comb ^ $past(stage_comb)) == (exec_fault ^ $past(exec_fault)));
    end

    if (REGISTER_OUT) begin : g_reg
        maj_out_reg #(.N(N)) u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .stage_in  (stage_comb),
            .stage_out (bundle_out)
        );
    end else begin : g_comb
        assign bundle_out = stage_comb;
    end

    // R6
    consensus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bundle_a == ALL_ONE && bundle_b == ALL_ONE && bundle_c == ALL_ONE &&
         exec_fault == '0 && rest_fault == '0) |-> stage_comb == ALL_ONE);

    // R6
    consensus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bundle_a == '0 && bundle_b == '0 && bundle_c == '0 &&
         exec_fault == '0 && rest_fault == '0) |-> stage_comb == '0);
endmodule

// File: tb/maj_mux_stage_test.sv
module maj_mux_stage_test;
    localparam int N      = 5;
    localparam int STRIDE = 7;
    localparam int OFFSET = 4;
    localparam logic [N-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] a = '0, b = '0, c = '0, ef = '0, rf = '0;
    logic [N-1:0] out_r, out_b;
    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    maj_mux_stage #(.N(N), .RESTORE(1'b1), .REGISTER_OUT(1'b1),
                    .PERM_STRIDE(STRIDE), .PERM_OFFSET(OFFSET)) uut (
        .clk(clk), .rst_n(rst_n), .bundle_a(a), .bundle_b(b), .bundle_c(c),
        .exec_fault(ef), .rest_fault(rf), .bundle_out(out_r));

    maj_mux_stage #(.N(N), .RESTORE(1'b0), .REGISTER_OUT(1'b0),
                    .PERM_STRIDE(STRIDE), .PERM_OFFSET(OFFSET)) uut_bypass (
        .clk(clk), .rst_n(rst_n), .bundle_a(a), .bundle_b(b), .bundle_c(c),
        .exec_fault(ef), .rest_fault(rf), .bundle_out(out_b));

    function automatic logic mmaj(input logic x, input logic y, input logic z);
        return (x + y + z) >= 2;
    endfunction

    function automatic logic [N-1:0] m_exec(input logic [N-1:0] xa, xb, xc, xf);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = mmaj(xa[i], xb[i], xc[i]) ^ xf[i];
        return r;
    endfunction

    function automatic logic [N-1:0] m_rest(input logic [N-1:0] e, input logic [N-1:0] xf);
        logic [N-1:0] r;
        logic [2:0] v;
        for (int g = 0; g < N; g++) begin
            for (int m = 0; m < 3; m++) v[m] = e[((((3*g+m) * STRIDE) + OFFSET) % (3*N)) % N];
            r[g] = mmaj(v[0], v[1], v[2]) ^ xf[g];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    typedef struct packed {
        logic [N-1:0] va, vb, vc, vef, vrf;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'b11111, 5'b11111, 5'b11111, 5'b00000, 5'b00000},
        '{5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000},
        '{5'b11011, 5'b11111, 5'b11111, 5'b00000, 5'b00000},
        '{5'b00000, 5'b01000, 5'b00000, 5'b00000, 5'b00000},
        '{5'b10101, 5'b01010, 5'b11100, 5'b00000, 5'b00000},
        '{5'b11001, 5'b00111, 5'b01110, 5'b00000, 5'b00000},
        '{5'b10000, 5'b10001, 5'b00011, 5'b00000, 5'b00000},
        '{5'b01101, 5'b11010, 5'b10011, 5'b00100, 5'b00000},
        '{5'b11100, 5'b00111, 5'b10101, 5'b00000, 5'b01001},
        '{5'b10110, 5'b01101, 5'b11011, 5'b10010, 5'b00110}
    };

    // Drive at a falling edge; registered result sampled at the next falling edge
    task automatic apply(input logic [N-1:0] xa, xb, xc, xef, xrf, input string req);
        @(negedge clk);
        a = xa; b = xb; c = xc; ef = xef; rf = xrf;
        @(negedge clk);
        check({req, " restored"}, out_r, m_rest(m_exec(xa, xb, xc, xef), xrf));
        check({req, " bypass"}, out_b, m_exec(xa, xb, xc, xef));
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R5 reset clears the registered output
        a = ONES; b = ONES; c = ONES;
        repeat (3) @(negedge clk);
        check("R5 reset", out_r, '0);
        rst_n = 1'b1;

        // R1 R2 R6 R8 table of mixed patterns
        for (int v = 0; v < NV; v++)
            apply(VECS[v].va, VECS[v].vb, VECS[v].vc, VECS[v].vef, VECS[v].vrf, "R2 R1 table");

        // R6 consensus
        apply(ONES, ONES, ONES, '0, '0, "R6 ones");
        check("R6 ones value", out_r, ONES);
        apply('0, '0, '0, '0, '0, "R6 zeros");
        check("R6 zeros value", out_r, '0);

        // R8 single input-line error corrected
        for (int i = 0; i < N; i++) begin
            apply(ONES ^ (5'b1 << i), ONES, ONES, '0, '0, "R8 line error");
            check("R8 corrected", out_r, ONES);
        end

        // R7 single first-layer fault masked; R1 visible on bypass
        for (int i = 0; i < N; i++) begin
            apply(ONES, ONES, ONES, 5'b1 << i, '0, "R7 exec fault ones");
            check("R7 masked ones", out_r, ONES);
            check("R1 bypass flip", out_b, ONES ^ (5'b1 << i));
            apply('0, '0, '0, 5'b1 << i, '0, "R7 exec fault zeros");
            check("R7 masked zeros", out_r, '0);
        end

        // R3 second-layer fault flips only its own line; R4 bypass unaffected
        for (int i = 0; i < N; i++) begin
            apply(ONES, ONES, ONES, '0, 5'b1 << i, "R3 rest fault");
            check("R3 single flip", out_r, ONES ^ (5'b1 << i));
            check("R4 ignored", out_b, ONES);
        end

        // R5 latency: result absent before the edge, present after
        @(negedge clk);
        a = '0; b = '0; c = '0; ef = '0; rf = '0;
        @(negedge clk);
        check("R5 settle", out_r, '0);
        a = ONES; b = ONES; c = ONES;
        #1;
        check("R5 before edge", out_r, '0);
        @(negedge clk);
        check("R5 after edge", out_r, ONES);

        // R5 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R5 mid reset", out_r, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 resume", out_r, ONES);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule